// File: doc/BRIEF.md
# Round-Robin Restricted-Collapse Issue Queue

This block is an age-ordered instruction queue that closes the gaps left by issued entries, but only inside a window that begins at a rotating pseudo-head slot. Slots below the pseudo-head are never moved. A hole in that lower part stays empty until the pseudo-head wraps back past it. Moving the start of the shifting window spreads the write activity over every slot. A queue that always compacts from slot 0 would instead concentrate that activity in the lowest slots. The cost is some loss of strict age ordering.

New entries go in at the tail. An external select drives one issue-request bit per slot. The queue shows the valid bit and the payload of every slot, together with the current pseudo-head. The dwell time of the pseudo-head is set by an input.

Top module: `rr_collapse_iq`

## Requirements
- R1: While `rst_n` is low at a rising edge, every slot becomes invalid, the pseudo-head becomes 0, the tail becomes 0 and `full` is 0.
- R2: When `ins_valid` is high and `full` is low, the payload is written as a valid entry into the slot given by the tail after that cycle's compaction. The tail is then one past that slot. When the old tail is at or below the old pseudo-head, the post-compaction tail equals the old tail. Otherwise it is the pseudo-head plus the number of entries that survive in the window.
- R3: A valid slot whose `iss_req` bit is high is removed at the next rising edge.
- R4: Slots at or above the pseudo-head form the collapse window (control bit set). Each surviving entry in the window moves down by the number of empty or issued slots between the pseudo-head and itself, so the window becomes dense from the pseudo-head upward and keeps its relative order.
- R5: Slots below the pseudo-head (control bit clear) are never shifted. A surviving entry there keeps its slot and payload, and a hole there stays empty while it remains below the pseudo-head.
- R6: A dwell counter, cleared by reset, advances the pseudo-head by one slot on each edge where the counter is greater than or equal to `rot_period`, and clears itself on that edge; otherwise it counts up by one. The pseudo-head wraps from DEPTH-1 to 0. With a constant `rot_period` of P, the pseudo-head moves every P+1 cycles. Over a long run, every slot receives writes.
- R7: `full` is high exactly when the tail equals DEPTH (the top slot holds the newest entry), even if holes remain below the pseudo-head. An insert presented while `full` is high is dropped.
- R8: An `iss_req` bit on an empty slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rot_period | input | PW | Dwell count of the pseudo-head (moves every value+1 cycles) |
| ins_valid | input | 1 | Insert request at the tail |
| ins_data | input | W | Payload to insert |
| iss_req | input | DEPTH | Per-slot issue request from the select logic |
| q_valid | output | DEPTH | Per-slot valid |
| q_data | output | DEPTH*W | Per-slot payload, slot i at bits i*W +: W |
| full | output | 1 | Tail has reached past the top slot |
| pseudo_head | output | $clog2(DEPTH) | Current start of the collapse window |

## Verification
The hardest state to reach is a full queue that still has holes below the pseudo-head. It needs the pseudo-head parked above slot 0, an issue below it, and then a refill up to the top slot. The stimulus gets there directly: it sets `rot_period` to 0 for a few cycles to walk the pseudo-head, raises it to hold the head still, issues a low slot and keeps inserting. Long random runs with small dwell values then make the window wrap often. This lets old holes be collapsed and gives every slot some writes.

// File: rtl/iq_pkg.sv
// Shared helpers for the restricted-collapse issue queue.
// Assumes: pointer arithmetic is done on plain ints before narrowing.
package iq_pkg;

    // Next slot index with wrap at the queue depth.
    function automatic int wrap_next(input int cur, input int depth);
        return (cur == depth - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/rr_ph_ctrl.sv
// Pseudo-head rotator and collapse-control vector generator.
// Moves the pseudo-head one slot, with wrap, each time the dwell counter
// reaches rot_period, and marks slots at or above it as collapsible.
// Assumes: DEPTH >= 2, rot_period may change at any cycle.
module rr_ph_ctrl #(
    parameter int DEPTH = 8,
    parameter int PW    = 8,
    localparam int PHW  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    rot_period,
    output logic [PHW-1:0]   ph,
    output logic [DEPTH-1:0] ctrl
);
    import iq_pkg::*;

    logic [PW-1:0] dwell;

    // Dwell counting and pseudo-head advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell <= '0;
            ph    <= '0;
        end else if (dwell >= rot_period) begin
            dwell <= '0;
            ph    <= PHW'(wrap_next(int'(ph), DEPTH));
        end else begin
            dwell <= dwell + PW'(1);
        end
    end

    // One control bit per slot: set from the pseudo-head upward.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ctrl
        assign ctrl[g] = (ph <= PHW'(g));
    end

endmodule

// File: rtl/iq_compactor.sv
// Combinational collapse network for the window above the pseudo-head.
// Slots with a clear control bit pass through unchanged; surviving slots
// with a set control bit are packed, in order, starting at the pseudo-head.
// Assumes: ctrl is a thermometer vector starting at ph.
module iq_compactor #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PHW  = $clog2(DEPTH),
    localparam int TW   = $clog2(DEPTH + 1)
) (
    input  logic [PHW-1:0]     ph,
    input  logic [DEPTH-1:0]   ctrl,
    input  logic [DEPTH-1:0]   live,
    input  logic [DEPTH*W-1:0] din,
    output logic [DEPTH-1:0]   vout,
    output logic [DEPTH*W-1:0] dout,
    output logic [TW-1:0]      kept
);
    int dst;

    // Pack live window entries downward, preserving their order.
    always_comb begin
        vout = live & ~ctrl;
        dout = din;
        kept = '0;
        dst  = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ctrl[i] && live[i]) begin
                dst = int'(ph) + int'(kept);
                vout[dst]          = 1'b1;
                dout[dst*W +: W]   = din[i*W +: W];
                kept               = kept + TW'(1);
            end
        end
    end

endmodule

// File: rtl/rr_collapse_iq.sv
// Issue queue with round-robin restricted collapse.
// Holds DEPTH entries of W bits; removes issued entries, compacts only the
// window at or above the rotating pseudo-head, then inserts at the tail.
// Assumes: iss_req bits on empty slots are harmless; one insert per cycle.
module rr_collapse_iq #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int PW    = 8,
    localparam int PHW  = $clog2(DEPTH),
    localparam int TW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PW-1:0]      rot_period,
    input  logic               ins_valid,
    input  logic [W-1:0]       ins_data,
    input  logic [DEPTH-1:0]   iss_req,
    output logic [DEPTH-1:0]   q_valid,
    output logic [DEPTH*W-1:0] q_data,
    output logic               full,
    output logic [PHW-1:0]     pseudo_head
);
    logic [DEPTH-1:0]   ctrl;
    logic [DEPTH-1:0]   live;
    logic [DEPTH-1:0]   c_valid;
    logic [DEPTH*W-1:0] c_data;
    logic [TW-1:0]      kept;
    logic [TW-1:0]      tail;
    logic [TW-1:0]      tail_post;
    logic               ins_ok;
    logic [DEPTH-1:0]   n_valid;
    logic [DEPTH*W-1:0] n_data;

    rr_ph_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ph (
        .clk        (clk),
        .rst_n      (rst_n),
        .rot_period (rot_period),
        .ph         (pseudo_head),
        .ctrl       (ctrl)
    );

    // Entries that survive this cycle's issue.
    assign live = q_valid & ~iss_req;

    iq_compactor #(.DEPTH(DEPTH), .W(W)) u_cmp (
        .ph   (pseudo_head),
        .ctrl (ctrl),
        .live (live),
        .din  (q_data),
        .vout (c_valid),
        .dout (c_data),
        .kept (kept)
    );

    // Tail position after compaction and insert acceptance.
    assign full      = (tail == TW'(DEPTH));
    assign ins_ok    = ins_valid && !full;
    assign tail_post = (tail <= TW'(pseudo_head)) ? tail : TW'(pseudo_head) + kept;

    // Merge the inserted entry into the compacted image.
    always_comb begin
        n_valid = c_valid;
        n_data  = c_data;
        if (ins_ok) begin
            n_valid[int'(tail_post)]          = 1'b1;
            n_data[int'(tail_post)*W +: W]    = ins_data;
        end
    end

    // Queue state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= '0;
            q_data  <= '0;
            tail    <= '0;
        end else begin
            q_valid <= n_valid;
            q_data  <= n_data;
            tail    <= tail_post + TW'(ins_ok);
        end
    end

endmodule

// File: rtl/rr_collapse_iq_chk.sv
// Port-level property checker for rr_collapse_iq, attached by bind.
// Assumes: synchronous active-low reset applied from time zero.
module rr_collapse_iq_chk #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    parameter int PW    = 8,
    localparam int PHW  = $clog2(DEPTH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic [DEPTH-1:0]   iss_req,
    input logic [DEPTH-1:0]   q_valid,
    input logic [DEPTH*W-1:0] q_data,
    input logic               full,
    input logic [PHW-1:0]     pseudo_head
);
    // R6
    ph_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pseudo_head == $past(pseudo_head)) ||
                         (pseudo_head == (($past(pseudo_head) == PHW'(DEPTH-1)) ?
                                          PHW'(0) : $past(pseudo_head) + PHW'(1))));

    // R2 R3
    count_cons_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($countones(q_valid) ==
            $past($countones(q_valid) - $countones(q_valid & iss_req)) +
            int'($past(ins_valid && !full))));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // R5
        hold_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(q_valid[i] && !iss_req[i] && (PHW'(i) < pseudo_head)))
            |-> (q_valid[i] && (q_data[i*W +: W] == $past(q_data[i*W +: W]))));
    end

    for (genvar j = 1; j < DEPTH; j++) begin : g_dense
        // R4
        window_dense_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && q_valid[j] && (PHW'(j-1) >= $past(pseudo_head)))
            |-> q_valid[j-1]);
    end

endmodule

bind rr_collapse_iq rr_collapse_iq_chk #(.DEPTH(DEPTH), .W(W), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .iss_req     (iss_req),
    .q_valid     (q_valid),
    .q_data      (q_data),
    .full        (full),
    .pseudo_head (pseudo_head)
);

// File: tb/tb_rr_collapse_iq.sv
// Self-checking bench: directed corners, then seeded random traffic,
// compared against a behavioural model built from the requirements.
module tb_rr_collapse_iq;
    localparam int D   = 8;
    localparam int W   = 8;
    localparam int PW  = 8;
    localparam int PHW = $clog2(D);

    logic               clk = 1'b0;
    logic               rst_n;
    logic [PW-1:0]      rot_period;
    logic               ins_valid;
    logic [W-1:0]       ins_data;
    logic [D-1:0]       iss_req;
    logic [D-1:0]       q_valid;
    logic [D*W-1:0]     q_data;
    logic               full;
    logic [PHW-1:0]     pseudo_head;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    bit [D-1:0]   mv;
    logic [W-1:0] md [D];
    int           mph, mtail, mcnt;
    int           wr_cnt [D];
    logic [W-1:0] prev_d [D];

    always #2.5 clk = ~clk;

    rr_collapse_iq #(.DEPTH(D), .W(W), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .rot_period(rot_period),
        .ins_valid(ins_valid), .ins_data(ins_data), .iss_req(iss_req),
        .q_valid(q_valid), .q_data(q_data), .full(full), .pseudo_head(pseudo_head)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mv = '0; mph = 0; mtail = 0; mcnt = 0;
        for (int i = 0; i < D; i++) md[i] = '0;
    endtask

    // Model one clock edge from the requirements (R2..R7).
    task automatic model_step();
        bit [D-1:0]   nv;
        logic [W-1:0] nd [D];
        int kept, tpost;
        bit fnow;
        fnow = (mtail == D);
        kept = 0;
        for (int i = 0; i < D; i++) begin
            nd[i] = md[i];
            nv[i] = (i < mph) ? (mv[i] && !iss_req[i]) : 1'b0;
        end
        for (int i = mph; i < D; i++) begin
            if (mv[i] && !iss_req[i]) begin
                nv[mph + kept] = 1'b1;
                nd[mph + kept] = md[i];
                kept++;
            end
        end
        tpost = (mtail <= mph) ? mtail : mph + kept;
        if (ins_valid && !fnow) begin
            nv[tpost] = 1'b1;
            nd[tpost] = ins_data;
            tpost++;
        end
        mtail = tpost;
        mv = nv;
        for (int i = 0; i < D; i++) md[i] = nd[i];
        if (mcnt >= int'(rot_period)) begin
            mcnt = 0;
            mph  = (mph == D - 1) ? 0 : mph + 1;
        end else begin
            mcnt++;
        end
    endtask

    task automatic compare_all();
        for (int i = 0; i < D; i++) begin
            check(q_valid[i] === mv[i], $sformatf("R4 valid slot %0d", i), int'(q_valid[i]), int'(mv[i]));
            if (mv[i])
                check(q_data[i*W +: W] === md[i], $sformatf("R4 data slot %0d", i),
                      int'(q_data[i*W +: W]), int'(md[i]));
            if (q_data[i*W +: W] !== prev_d[i]) wr_cnt[i]++;
            prev_d[i] = q_data[i*W +: W];
        end
        check(full === (mtail == D), "R7 full", int'(full), int'(mtail == D));
        check(int'(pseudo_head) == mph, "R6 pseudo_head", int'(pseudo_head), mph);
    endtask

    // Apply one cycle of stimulus at the falling edge and check after the next rise.
    task automatic cyc(input bit iv, input logic [W-1:0] id, input logic [D-1:0] ir);
        ins_valid = iv; ins_data = id; iss_req = ir;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < D; i++) begin wr_cnt[i] = 0; prev_d[i] = '0; end
        rst_n = 1'b0; rot_period = 8'd255; ins_valid = 1'b0; ins_data = '0; iss_req = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(q_valid == '0, "R1 valid after reset", int'(q_valid), 0);
        check(full == 1'b0, "R1 full after reset", int'(full), 0);
        check(pseudo_head == '0, "R1 pseudo_head after reset", int'(pseudo_head), 0);
        rst_n = 1'b1;

        // R2: three inserts land at slots 0..2 with pseudo-head held at 0
        cyc(1'b1, 8'hA1, '0);
        cyc(1'b1, 8'hB2, '0);
        cyc(1'b1, 8'hC3, '0);
        check(q_valid[2:0] == 3'b111 && q_data[2*W +: W] == 8'hC3, "R2 insert at tail",
              int'(q_data[2*W +: W]), 8'hC3);

        // R3 R4: issue slot 1, slot 2 moves down to slot 1
        cyc(1'b0, '0, 8'b0000_0010);
        check(q_valid[2:0] == 3'b011 && q_data[W +: W] == 8'hC3, "R3 R4 issue and collapse",
              int'(q_data[W +: W]), 8'hC3);

        // R8: issue request on an empty slot changes nothing
        cyc(1'b0, '0, 8'b0010_0000);
        check(q_valid == 8'b0000_0011 && q_data[W +: W] == 8'hC3, "R8 empty issue ignored",
              int'(q_valid), 3);

        // R6: walk the pseudo-head to slot 3, then hold it
        rot_period = 8'd0;
        repeat (3) cyc(1'b0, '0, '0);
        rot_period = 8'd255;
        cyc(1'b1, 8'hD4, '0);
        check(pseudo_head == 3'd3, "R6 pseudo-head walk", int'(pseudo_head), 3);

        // R5: issue slot 0 below the pseudo-head; hole stays, slot 1 unmoved
        cyc(1'b0, '0, 8'b0000_0001);
        check(q_valid[0] == 1'b0 && q_valid[1] == 1'b1 && q_data[W +: W] == 8'hC3,
              "R5 hole below pseudo-head kept", int'(q_valid[1:0]), 2);

        // R7: fill to the top slot; full despite the hole at slot 0
        for (int k = 0; k < 8 && !full; k++) cyc(1'b1, W'(8'h10 + k), '0);
        check(full == 1'b1 && q_valid[0] == 1'b0, "R7 full with hole", int'(full), 1);
        cyc(1'b1, 8'hEE, '0);
        check($countones(q_valid) == D - 1, "R7 insert dropped when full",
              $countones(q_valid), D - 1);

        // Random traffic with small dwell values so the window wraps often
        for (int n = 0; n < 4000; n++) begin
            if (n % 97 == 0) rot_period = PW'($urandom_range(0, 5));
            cyc(($urandom_range(0, 9) < 7), W'($urandom), D'($urandom & $urandom));
        end

        // R6: every slot received writes over the run
        for (int i = 0; i < D; i++)
            check(wr_cnt[i] > 0, $sformatf("R6 write spread slot %0d", i), wr_cnt[i], 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule